// File: doc/BRIEF.md
# Reference Select and Holdover Controller

This block is the digital control core of a clock generator that has two reference inputs. It holds a small register bank that software can write and read. From the enable mode and the per-input failure flags it picks the active reference. It raises a sticky alarm and an interrupt when it fails over to the other input. When no usable input remains, or when software forces it, it enters holdover. In holdover the oscillator is steered by a stored nominal control word instead of the PLL's live word.

Software can also capture the live PLL word at a chosen moment and steer the oscillator from it. The block drives the enable and force-low controls of two clock outputs and the divider choice for a third. A master-reset pin, or a register bit that acts like it, returns every register to its power-up value.

Top module: `refsel_holdover_ctrl`

## Requirements
- R1: After reset, register 5 reads 0x60 and registers 0 to 4, 6, 7 and 8 read 0x00. Registers 0 to 4 read back the last byte written to them. A register changes only when it is written or reset.
- R2: The input-enable field is register 5 bits [3:2]. Its codes are: 00 = pin control, 01 = IN0 only, 10 = IN1 only, 11 = both. Under pin control, sel_pins_i 00 enables IN0 only, 01 enables IN1 only, 10 enables both and 11 enables neither. A disabled input is never chosen and counts as unusable.
- R3: An input is healthy when it is enabled and its fail_i bit (bit 0 = IN0, bit 1 = IN1) is low. If the active input is not healthy and the other input is, the block switches to the other input on the next clock edge. The same edge sets the sticky alarm (register 7 bit 7) and irq_o.
- R4: With revert off (register 5 bit 1 = 0), the block stays on a healthy active input, even after the other input recovers. If neither input is healthy, the active input does not change.
- R5: With revert on, if the active input is healthy but is not the default input (register 5 bit 4: 0 = IN0, 1 = IN1), the block returns to the default as soon as the default is healthy. A return of this kind does not set the alarm.
- R6: A write to register 5 with bits 1 and 0 both set is a monitor reset. It clears the alarm and irq_o and makes the newly written default input active. It takes priority over a failover in the same cycle. Bit 0 always reads 0.
- R7: Register 5 bit 6 enables CLK0 and bit 5 enables CLK1 (clk_oe_o[0] and clk_oe_o[1]). Register 5 bit 7 forces every enabled output low on clk_low_o. A disabled output never shows force-low.
- R8: holdover_o is high when register 6 bit 6 (forced) is set, or when register 6 bit 7 (enable) is set and no input is healthy. In holdover, osc_word_o carries the stored nominal word.
- R9: A write that takes register 6 bit 5 or bit 6 from 0 to 1 captures pll_word_i as the nominal word. Otherwise the nominal word does not change.
- R10: Outside holdover, osc_word_o is pll_word_i when register 6 bit 1 = 0. When that bit is 1, it is the word captured at the last 0-to-1 write of register 6 bit 5.
- R11: mr_i high at a clock edge, or a write to register 6 with bit 4 set, returns all state to its reset values. A write in the same cycle is discarded.
- R12: Register 7 is read-only and shows bit 7 alarm, bit 6 IN0 failed, bit 5 IN1 failed, bit 4 active input (1 = IN1), bit 3 PLL not locked, bit 2 holdover, and zeros in bits 1:0. Register 6 bits 4, 3 and 0 read 0. Register 8 reads 0 and ignores writes. clk2_div_sel_o follows register 6 bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mr_i | input | 1 | Synchronous master reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| sel_pins_i | input | 2 | Input-enable select pins |
| fail_i | input | 2 | Per-input failure flags |
| pll_lock_i | input | 1 | PLL locked |
| pll_word_i | input | WORD_W | Live PLL oscillator control word |
| osc_word_o | output | WORD_W | Word steering the oscillator |
| active_in_o | output | 1 | Active reference (1 = IN1) |
| holdover_o | output | 1 | Holdover in effect |
| irq_o | output | 1 | Failover interrupt (sticky alarm) |
| clk_oe_o | output | 2 | Output drive enables for CLK0/CLK1 |
| clk_low_o | output | 2 | Force-low for CLK0/CLK1 |
| clk2_div_sel_o | output | 1 | Divider feeding CLK2 (1 = second divider) |

## Verification
A monitor-reset write and a failover can fall due on the same clock edge. One asks for the default input with the alarm cleared, the other for the opposite input with the alarm set. The bench raises the IN0 failure flag in the same cycle as a monitor-reset write that names IN0 as default, while IN1 is healthy. It expects IN0 active with the alarm clear after that edge, and the failover with the alarm set one edge later. The reference model applies the same priority on every cycle, and directed checks pin down both edges.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  localparam int NUM_GEN   = 5;
  localparam int ADDR_CR5  = 5;
  localparam int ADDR_CR6  = 6;
  localparam int ADDR_STAT = 7;

  localparam logic [7:0] CR5_RST  = 8'h60;
  localparam logic [7:0] CR5_KEEP = 8'hFE;
  localparam logic [7:0] CR6_KEEP = 8'hE6;

  localparam int C5_LOW  = 7;
  localparam int C5_CLK0 = 6;
  localparam int C5_CLK1 = 5;
  localparam int C5_DFLT = 4;
  localparam int C5_MODE = 2;
  localparam int C5_REV  = 1;
  localparam int C5_MRST = 0;

  localparam int C6_HEN  = 7;
  localparam int C6_HFRC = 6;
  localparam int C6_ACQ  = 5;
  localparam int C6_SRST = 4;
  localparam int C6_DIV  = 2;
  localparam int C6_ASEL = 1;

  typedef enum logic [1:0] {
    EN_PINS = 2'b00,
    EN_IN0  = 2'b01,
    EN_IN1  = 2'b10,
    EN_BOTH = 2'b11
  } en_mode_e;

  function automatic logic [1:0] input_enables(input en_mode_e mode, input logic [1:0] sel);
    logic [1:0] en;
    case (mode)
      EN_IN0:  en = 2'b01;
      EN_IN1:  en = 2'b10;
      EN_BOTH: en = 2'b11;
      default: begin
        case (sel)
          2'b00:   en = 2'b01;
          2'b01:   en = 2'b10;
          2'b10:   en = 2'b11;
          default: en = 2'b00;
        endcase
      end
    endcase
    return en;
  endfunction
endpackage

// File: rtl/refsel_regs.sv
module refsel_regs
  import refsel_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rd_o,
  output logic              out_low_o,
  output logic              clk0_en_o,
  output logic              clk1_en_o,
  output logic              dflt_o,
  output en_mode_e          mode_o,
  output logic              revert_o,
  output logic              hold_en_o,
  output logic              hold_force_o,
  output logic              acq_sel_o,
  output logic              div_sel_o,
  output logic              mon_rst_o,
  output logic              mon_dflt_o,
  output logic              cap_hold_o,
  output logic              cap_acq_o
);
  logic [7:0] gen_q [NUM_GEN];
  logic [7:0] cr5_q, cr6_q;
  logic       wr5, wr6;

  assign wr5 = wr_en_i && (addr_i == ADDR_W'(ADDR_CR5));
  assign wr6 = wr_en_i && (addr_i == ADDR_W'(ADDR_CR6));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_GEN; i++) gen_q[i] <= 8'h00;
      cr5_q <= CR5_RST;
      cr6_q <= 8'h00;
    end else if (srst_i) begin
      for (int i = 0; i < NUM_GEN; i++) gen_q[i] <= 8'h00;
      cr5_q <= CR5_RST;
      cr6_q <= 8'h00;
    end else begin
      for (int i = 0; i < NUM_GEN; i++)
        if (wr_en_i && addr_i == ADDR_W'(i)) gen_q[i] <= wdata_i;
      if (wr5) cr5_q <= wdata_i & CR5_KEEP;
      if (wr6) cr6_q <= wdata_i & CR6_KEEP;
    end
  end

  always_comb begin
    rd_o = 8'h00;
    for (int i = 0; i < NUM_GEN; i++)
      if (addr_i == ADDR_W'(i)) rd_o = gen_q[i];
    if (addr_i == ADDR_W'(ADDR_CR5)) rd_o = cr5_q;
    if (addr_i == ADDR_W'(ADDR_CR6)) rd_o = cr6_q;
  end

  assign out_low_o    = cr5_q[C5_LOW];
  assign clk0_en_o    = cr5_q[C5_CLK0];
  assign clk1_en_o    = cr5_q[C5_CLK1];
  assign dflt_o       = cr5_q[C5_DFLT];
  assign mode_o       = en_mode_e'(cr5_q[C5_MODE+:2]);
  assign revert_o     = cr5_q[C5_REV];
  assign hold_en_o    = cr6_q[C6_HEN];
  assign hold_force_o = cr6_q[C6_HFRC];
  assign acq_sel_o    = cr6_q[C6_ASEL];
  assign div_sel_o    = cr6_q[C6_DIV];

  // monitor reset needs revert requested in the same write
  assign mon_rst_o  = wr5 && wdata_i[C5_REV] && wdata_i[C5_MRST];
  assign mon_dflt_o = wdata_i[C5_DFLT];
  assign cap_acq_o  = wr6 && wdata_i[C6_ACQ] && !cr6_q[C6_ACQ];
  assign cap_hold_o = cap_acq_o || (wr6 && wdata_i[C6_HFRC] && !cr6_q[C6_HFRC]);

  AST_CR5_ONLY_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr5 && !srst_i) |=> $stable(cr5_q)); // R1
  AST_CR6_ONLY_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr6 && !srst_i) |=> $stable(cr6_q)); // R1
endmodule

// File: rtl/refsel_monitor.sv
module refsel_monitor (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       srst_i,
  input  logic [1:0] en_i,
  input  logic [1:0] fail_i,
  input  logic       revert_i,
  input  logic       dflt_i,
  input  logic       mon_rst_i,
  input  logic       mon_dflt_i,
  output logic       active_o,
  output logic       alarm_o,
  output logic [1:0] healthy_o
);
  logic act_q, act_d, alarm_q, alarm_d;
  logic [1:0] healthy;

  assign healthy = en_i & ~fail_i;

  always_comb begin
    act_d   = act_q;
    alarm_d = alarm_q;
    if (mon_rst_i) begin
      act_d   = mon_dflt_i;
      alarm_d = 1'b0;
    end else if (!healthy[act_q]) begin
      if (healthy[!act_q]) begin
        act_d   = !act_q;
        alarm_d = 1'b1;
      end
    end else if (revert_i && (act_q != dflt_i) && healthy[dflt_i]) begin
      act_d = dflt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      alarm_q <= 1'b0;
    end else if (srst_i) begin
      act_q   <= 1'b0;
      alarm_q <= 1'b0;
    end else begin
      act_q   <= act_d;
      alarm_q <= alarm_d;
    end
  end

  assign active_o  = act_q;
  assign alarm_o   = alarm_q;
  assign healthy_o = healthy;

  AST_SWITCH_ON_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && !mon_rst_i && !healthy[act_q] && healthy[!act_q])
      |=> (act_q != $past(act_q)) && alarm_q); // R3
  AST_ALARM_NEEDS_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_q) |-> (act_q != $past(act_q))); // R3
  AST_NONREVERT_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && !mon_rst_i && !revert_i && healthy[act_q]) |=> $stable(act_q)); // R4
  AST_MONRST_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && mon_rst_i) |=> (act_q == $past(mon_dflt_i)) && !alarm_q); // R6
endmodule

// File: rtl/refsel_holdover.sv
module refsel_holdover #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              cap_hold_i,
  input  logic              cap_acq_i,
  input  logic [WORD_W-1:0] pll_word_i,
  input  logic              hold_en_i,
  input  logic              force_i,
  input  logic              acq_sel_i,
  input  logic [1:0]        healthy_i,
  output logic              holdover_o,
  output logic [WORD_W-1:0] osc_word_o
);
  logic [WORD_W-1:0] hold_q, acq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      acq_q  <= '0;
    end else if (srst_i) begin
      hold_q <= '0;
      acq_q  <= '0;
    end else begin
      if (cap_hold_i) hold_q <= pll_word_i;
      if (cap_acq_i)  acq_q  <= pll_word_i;
    end
  end

  assign holdover_o = force_i || (hold_en_i && (healthy_i == 2'b00));
  assign osc_word_o = holdover_o ? hold_q : (acq_sel_i ? acq_q : pll_word_i);

  AST_HOLD_WORD_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && !cap_hold_i) |=> $stable(hold_q)); // R9
  AST_ACQ_WORD_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && !cap_acq_i) |=> $stable(acq_q)); // R10
endmodule

// File: rtl/refsel_holdover_ctrl.sv
module refsel_holdover_ctrl
  import refsel_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [1:0]        sel_pins_i,
  input  logic [1:0]        fail_i,
  input  logic              pll_lock_i,
  input  logic [WORD_W-1:0] pll_word_i,
  output logic [WORD_W-1:0] osc_word_o,
  output logic              active_in_o,
  output logic              holdover_o,
  output logic              irq_o,
  output logic [1:0]        clk_oe_o,
  output logic [1:0]        clk_low_o,
  output logic              clk2_div_sel_o
);
  logic       srst;
  logic [7:0] rd_bank, status;
  logic       out_low, clk0_en, clk1_en, dflt, revert;
  logic       hold_en, hold_force, acq_sel, div_sel;
  logic       mon_rst, mon_dflt, cap_hold, cap_acq;
  logic       alarm;
  logic [1:0] healthy;
  en_mode_e   mode;

  // soft reset from pin or from the reset bit of register 6
  assign srst = mr_i || (wr_en_i && (addr_i == ADDR_W'(ADDR_CR6)) && wdata_i[C6_SRST]);

  refsel_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .srst_i(srst), .wr_en_i, .addr_i, .wdata_i,
    .rd_o(rd_bank), .out_low_o(out_low), .clk0_en_o(clk0_en), .clk1_en_o(clk1_en),
    .dflt_o(dflt), .mode_o(mode), .revert_o(revert), .hold_en_o(hold_en),
    .hold_force_o(hold_force), .acq_sel_o(acq_sel), .div_sel_o(div_sel),
    .mon_rst_o(mon_rst), .mon_dflt_o(mon_dflt), .cap_hold_o(cap_hold), .cap_acq_o(cap_acq)
  );

  refsel_monitor u_mon (
    .clk_i, .rst_ni, .srst_i(srst),
    .en_i(input_enables(mode, sel_pins_i)), .fail_i,
    .revert_i(revert), .dflt_i(dflt), .mon_rst_i(mon_rst), .mon_dflt_i(mon_dflt),
    .active_o(active_in_o), .alarm_o(alarm), .healthy_o(healthy)
  );

  refsel_holdover #(.WORD_W(WORD_W)) u_hold (
    .clk_i, .rst_ni, .srst_i(srst), .cap_hold_i(cap_hold), .cap_acq_i(cap_acq),
    .pll_word_i, .hold_en_i(hold_en), .force_i(hold_force), .acq_sel_i(acq_sel),
    .healthy_i(healthy), .holdover_o, .osc_word_o
  );

  assign status  = {alarm, fail_i[0], fail_i[1], active_in_o, !pll_lock_i, holdover_o, 2'b00};
  assign rdata_o = (addr_i == ADDR_W'(ADDR_STAT)) ? status : rd_bank;
  assign irq_o   = alarm;

  // tri-state wins over force-low
  assign clk_oe_o       = {clk1_en, clk0_en};
  assign clk_low_o      = {2{out_low}} & clk_oe_o;
  assign clk2_div_sel_o = div_sel;

  AST_SRST_CLEARS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> !irq_o && !active_in_o); // R11
endmodule

// File: tb/sim_refsel_holdover_ctrl.sv
module sim_refsel_holdover_ctrl;
  localparam int WW = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mr = 1'b0, we = 1'b0, lock = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wd = '0;
  logic [1:0]    sel = 2'b00, fail = 2'b00;
  logic [WW-1:0] pw = 16'h0100;
  logic [7:0]    rdata;
  logic [WW-1:0] osc;
  logic          act, hold, irq, div;
  logic [1:0]    oe, low;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  refsel_holdover_ctrl #(.WORD_W(WW), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mr_i(mr), .wr_en_i(we), .addr_i(addr), .wdata_i(wd),
    .rdata_o(rdata), .sel_pins_i(sel), .fail_i(fail), .pll_lock_i(lock), .pll_word_i(pw),
    .osc_word_o(osc), .active_in_o(act), .holdover_o(hold), .irq_o(irq),
    .clk_oe_o(oe), .clk_low_o(low), .clk2_div_sel_o(div)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]    m_reg [9];
  logic          m_act, m_alarm;
  logic [WW-1:0] m_hold, m_acq;

  task automatic m_reset();
    for (int i = 0; i < 9; i++) m_reg[i] = 8'h00;
    m_reg[5] = 8'h60;
    m_act = 1'b0; m_alarm = 1'b0; m_hold = '0; m_acq = '0;
  endtask

  function automatic logic [1:0] m_healthy();
    logic [1:0] en;
    case (m_reg[5][3:2])
      2'b01: en = 2'b01;
      2'b10: en = 2'b10;
      2'b11: en = 2'b11;
      default: en = (sel == 2'b00) ? 2'b01 : (sel == 2'b01) ? 2'b10 : (sel == 2'b10) ? 2'b11 : 2'b00;
    endcase
    return en & ~fail;
  endfunction

  function automatic logic m_holdover();
    return m_reg[6][6] || (m_reg[6][7] && m_healthy() == 2'b00);
  endfunction

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else if (mr || (we && addr == 6 && wd[4])) m_reset();
    else begin
      logic [1:0] h;
      logic na, nal, dft;
      h = m_healthy();
      na = m_act; nal = m_alarm; dft = m_reg[5][4];
      if (we && addr == 5 && wd[1] && wd[0]) begin na = wd[4]; nal = 1'b0; end
      else if (!h[m_act]) begin
        if (h[!m_act]) begin na = !m_act; nal = 1'b1; end
      end else if (m_reg[5][1] && m_act != dft && h[dft]) na = dft;
      if (we && addr == 6) begin
        if (wd[5] && !m_reg[6][5]) begin m_acq = pw; m_hold = pw; end
        if (wd[6] && !m_reg[6][6]) m_hold = pw;
      end
      if (we) begin
        if (addr < 5) m_reg[addr] = wd;
        else if (addr == 5) m_reg[5] = wd & 8'hFE;
        else if (addr == 6) m_reg[6] = wd & 8'hE6;
      end
      m_act = na; m_alarm = nal;
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] er;
      logic eh;
      eh = m_holdover();
      if (addr <= 6) er = m_reg[addr];
      else if (addr == 7) er = {m_alarm, fail[0], fail[1], m_act, !lock, eh, 2'b00};
      else er = 8'h00;
      chk("R3 model active", act, m_act);
      chk("R6 model irq", irq, m_alarm);
      chk("R8 model holdover", hold, eh);
      chk("R10 model osc word", osc, eh ? m_hold : (m_reg[6][1] ? m_acq : pw));
      chk("R7 model oe", oe, {m_reg[5][5], m_reg[5][6]});
      chk("R7 model low", low, {m_reg[5][5], m_reg[5][6]} & {2{m_reg[5][7]}});
      chk("R12 model div", div, m_reg[6][2]);
      chk("R12 model rdata", rdata, er);
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    tick(1);
    we = 1'b1; addr = a; wd = d;
    tick(1);
    we = 1'b0;
  endtask

  task automatic expect_rd(input string tag, input logic [AW-1:0] a, input logic [7:0] exp);
    tick(1);
    addr = a;
    #2 chk(tag, rdata, exp);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    // R1 reset values
    expect_rd("R1 reset reg5", 5, 8'h60);
    for (int i = 0; i < 5; i++) expect_rd("R1 reset gen", AW'(i), 8'h00);
    expect_rd("R1 reset reg6", 6, 8'h00);
    expect_rd("R1 reset reg7", 7, 8'h00);
    expect_rd("R1 reset reg8", 8, 8'h00);
    for (int i = 0; i < 5; i++) wr(AW'(i), 8'hA0 + 8'(i));
    for (int i = 0; i < 5; i++) expect_rd("R1 readback", AW'(i), 8'hA0 + 8'(i));

    // R2/R4 pins 00: IN0 only, IN0 fails, nowhere to go
    tick(1); fail = 2'b01;
    tick(3); #2 chk("R4 stays when no healthy", act, 1'b0);
    chk("R8 holdover off when disabled", hold, 1'b0);

    // R3 pins 10 enable both -> failover
    tick(1); sel = 2'b10;
    tick(1); #2 chk("R3 switched to IN1", act, 1'b1);
    chk("R3 irq set", irq, 1'b1);
    expect_rd("R12 status after failover", 7, 8'hD0);

    // R4 recovery, non-revertive
    tick(1); fail = 2'b00;
    tick(3); #2 chk("R4 no return", act, 1'b1);

    // R6 monitor reset: mode both, revert, default IN0
    wr(5, 8'h6F);
    #2 chk("R6 back to default", act, 1'b0);
    chk("R6 irq cleared", irq, 1'b0);
    expect_rd("R6 bit0 reads zero", 5, 8'h6E);

    // R5 revert
    tick(1); fail = 2'b01;
    tick(1); #2 chk("R3 failover in revert mode", act, 1'b1);
    tick(1); fail = 2'b00;
    tick(1); #2 chk("R5 reverted to default", act, 1'b0);

    // R2 mode 01: IN1 disabled even when healthy
    wr(5, 8'h64);
    tick(1); fail = 2'b01;
    tick(2); #2 chk("R2 disabled input not chosen", act, 1'b0);
    wr(6, 8'h80);
    #2 chk("R8 holdover entered", hold, 1'b1);
    chk("R8 nominal word at reset", osc, 16'h0000);

    // R9 capture on rising bit 5
    tick(1); pw = 16'h1234;
    wr(6, 8'hA0);
    tick(1); pw = 16'h5555;
    #2 chk("R9 captured nominal", osc, 16'h1234);

    // R10 acquire select
    tick(1); fail = 2'b00;
    tick(1); #2 chk("R10 live word", osc, 16'h5555);
    wr(6, 8'hA2);
    #2 chk("R10 acquired word", osc, 16'h1234);

    // R9/R8 forced holdover captures on bit 6 rise
    wr(6, 8'hC2);
    #2 chk("R8 forced holdover", hold, 1'b1);
    chk("R9 capture on force", osc, 16'h5555);
    tick(1); pw = 16'h7777;
    wr(6, 8'hC2);
    #2 chk("R9 no capture without rise", osc, 16'h5555);
    wr(6, 8'h00);

    // R7 outputs
    wr(5, 8'hE0);
    #2 chk("R7 oe both", oe, 2'b11);
    chk("R7 low both", low, 2'b11);
    wr(5, 8'hA0);
    #2 chk("R7 clk0 tristate", oe, 2'b10);
    chk("R7 tristate beats low", low, 2'b10);
    wr(5, 8'h80);
    #2 chk("R7 none low when tristated", low, 2'b00);
    wr(5, 8'h60);

    // R12 register details
    wr(6, 8'h0D);
    #2 chk("R12 div select", div, 1'b1);
    expect_rd("R12 reg6 reserved zero", 6, 8'h04);
    wr(7, 8'hFF);
    expect_rd("R12 status read-only", 7, 8'h80);
    wr(8, 8'hFF);
    expect_rd("R12 reg8 zero", 8, 8'h00);
    wr(6, 8'h00);

    // R2 pins 11 enable none -> holdover
    tick(1); sel = 2'b11;
    wr(6, 8'h80);
    #2 chk("R2 pins none gives holdover", hold, 1'b1);
    wr(6, 8'h00);
    tick(1); sel = 2'b10;

    // same-cycle: monitor reset vs failover
    tick(1); fail = 2'b01; we = 1'b1; addr = 5; wd = 8'h6F;
    tick(1); we = 1'b0;
    #2 chk("R6 monitor reset wins", act, 1'b0);
    chk("R6 alarm clear on collision", irq, 1'b0);
    tick(1); #2 chk("R3 failover next edge", act, 1'b1);
    chk("R3 alarm next edge", irq, 1'b1);

    // R11 master reset pin, write discarded
    wr(0, 8'h5A);
    tick(1); mr = 1'b1; we = 1'b1; addr = 1; wd = 8'h77;
    tick(1); mr = 1'b0; we = 1'b0;
    #2 chk("R11 irq cleared", irq, 1'b0);
    expect_rd("R11 reg0 reset", 0, 8'h00);
    expect_rd("R11 write discarded", 1, 8'h00);
    expect_rd("R11 reg5 reset", 5, 8'h60);
    tick(1); fail = 2'b00;
    wr(2, 8'h33);
    wr(6, 8'h10);
    expect_rd("R11 soft reset reg2", 2, 8'h00);
    expect_rd("R11 soft reset reg6", 6, 8'h00);

    tick(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule